// File: doc/BRIEF.md
# Program/Erase Status Reporter

This block produces the completion status that a flash-style storage macro shows on its read data path and on its ready line while an internally timed write runs. A single-cycle start pulse launches either a byte program or a full erase. The block captures the loaded byte's most significant bit and then counts a fixed number of clock cycles, which depends on the operation kind. Until the count runs out, any read is answered with polling information in place of the upper two array bits.

Three completion indicators run in parallel. The top data bit carries the inverse of the loaded byte's top bit. The next bit alternates on every read strobe. A drive-low enable for a shared, wired-OR ready line is held for the whole operation. When the operation ends, a one-cycle done pulse marks the cycle in which the ready line is released, and reads return plain array data again. The array and the command decoding sit outside this block.

Top module: `pe_status_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following cycle shows `busy_drv_o`=0 and `done_o`=0, and the alternating bit state returns to 0. `rd_oe_o` is 0 in any cycle in which `rst_n` is low.
- R2: A `start_i` pulse with `op_erase_i`=0 (byte program), accepted while idle, holds `busy_drv_o` at 1 for exactly PROG_CYCLES cycles, starting with the cycle after the pulse.
- R3: A `start_i` pulse with `op_erase_i`=1 (erase), accepted while idle, holds `busy_drv_o` at 1 for exactly ERASE_CYCLES cycles, starting with the cycle after the pulse.
- R4: `done_o` is 1 for exactly one cycle: the first cycle in which `busy_drv_o` is 0 again after an operation that was not aborted.
- R5: During a byte program, bit 7 of `rd_byte_o` is the inverse of bit 7 of `load_byte_i` as sampled with the start pulse, whatever the array data being read.
- R6: During an erase, bit 7 of `rd_byte_o` is 0.
- R7: While busy, bit 6 of `rd_byte_o` shows the alternating state, which inverts after every cycle that has `rd_i`=1. Cycles without a read leave it unchanged. The first read after reset returns 0, and the state carries over unchanged from one operation to the next.
- R8: While busy, bits 5..0 of `rd_byte_o` equal `array_byte_i`. While idle, all eight bits equal `array_byte_i`, and reads do not change the alternating state.
- R9: A `start_i` pulse while busy is ignored: it neither lengthens the operation nor changes the captured bit 7.
- R10: Reset during an operation aborts it: `busy_drv_o` is 0 from the cycle after the reset edge, and no `done_o` pulse follows.
- R11: With `rst_n` high, `rd_oe_o` follows `rd_i` in the same cycle.
- R12: A start pulse in the same cycle as `done_o` is accepted and begins a new operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also aborts a running operation |
| start_i | input | 1 | One-cycle launch pulse |
| op_erase_i | input | 1 | Operation kind: 0 byte program, 1 erase |
| load_byte_i | input | DATA_W | Byte being programmed, sampled with start_i |
| rd_i | input | 1 | Read strobe |
| array_byte_i | input | DATA_W | Data read from the storage array |
| rd_byte_o | output | DATA_W | Byte presented to the reader |
| rd_oe_o | output | 1 | Read data drive enable (0 means high impedance) |
| busy_drv_o | output | 1 | Drive-low enable for the shared ready line |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two coincidences need care. The first is the end of an operation landing in the same cycle as a new start pulse. The bench raises start in the done cycle and expects busy again on the next cycle, with the new top bit captured. The second is a read strobe in the last busy cycle. That read must still get polling data and invert the alternating bit, and the read one cycle later, in the done cycle, must get raw array data.

// File: rtl/pe_status_pkg.sv
// Shared type for the program/erase status reporter.
package pe_status_pkg;
    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } op_kind_e;
endpackage

// File: rtl/pe_op_timer.sv
// Operation timer: accepts a start pulse while idle, holds busy for a
// duration chosen by the operation kind, then pulses done once.
// Assumes PROG_CYCLES and ERASE_CYCLES are at least 1.
module pe_op_timer
    import pe_status_pkg::*;
#(
    parameter int PROG_CYCLES  = 40,
    parameter int ERASE_CYCLES = 300
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_i,
    input  op_kind_e op_i,
    output logic     accept_o,
    output logic     busy_o,
    output logic     done_o
);
    localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CW      = $clog2(MAX_CYC + 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic          done_q;

    // Start is honoured only while no operation runs.
    assign accept_o = start_i && !busy_q;

    // Count down the remaining busy cycles and flag the final release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept_o) begin
                busy_q <= 1'b1;
                cnt_q  <= (op_i == OP_ERASE) ? CW'(ERASE_CYCLES - 1) : CW'(PROG_CYCLES - 1);
            end else if (busy_q) begin
                if (cnt_q == '0) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;

    p_done_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!busy_q && $past(busy_q)));
    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pe_poll_tracker.sv
// Polling state: keeps the top-bit status captured at launch and the
// bit that alternates on each read while busy. Assumes accept_i only
// pulses while idle.
module pe_poll_tracker
    import pe_status_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     accept_i,
    input  op_kind_e op_i,
    input  logic     load_msb_i,
    input  logic     rd_i,
    input  logic     busy_i,
    output logic     poll_msb_o,
    output logic     tog_o
);
    logic msb_q;
    logic tog_q;

    // Capture the inverted top bit for a program; an erase reads 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msb_q <= 1'b0;
        end else if (accept_i) begin
            msb_q <= (op_i == OP_ERASE) ? 1'b0 : !load_msb_i;
        end
    end

    // Invert the alternating bit after every read made while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
        end else if (rd_i && busy_i) begin
            tog_q <= !tog_q;
        end
    end

    assign poll_msb_o = msb_q;
    assign tog_o      = tog_q;

    p_toggle_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && busy_i) |=> (tog_q != $past(tog_q)));
    p_toggle_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |=> $stable(tog_q));
    p_msb_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && $past(busy_i)) |-> $stable(msb_q));
endmodule

// File: rtl/pe_read_mux.sv
// Read path: replaces the two top array bits with polling status while
// busy, and gates the drive enable with reset. Assumes DATA_W >= 3.
module pe_read_mux #(
    parameter int DATA_W = 8
) (
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic              busy_i,
    input  logic              poll_msb_i,
    input  logic              tog_i,
    input  logic [DATA_W-1:0] array_i,
    output logic [DATA_W-1:0] rd_byte_o,
    output logic              rd_oe_o
);
    localparam int MSB_BIT = DATA_W - 1;
    localparam int TOG_BIT = DATA_W - 2;

    // Build the presented byte from array data and status bits.
    always_comb begin
        rd_byte_o = array_i;
        if (busy_i) begin
            rd_byte_o[MSB_BIT] = poll_msb_i;
            rd_byte_o[TOG_BIT] = tog_i;
        end
    end

    // Drive only on a read, and never while reset is held.
    assign rd_oe_o = rd_i && rst_n;
endmodule

// File: rtl/pe_status_top.sv
// Program/erase status reporter top: ties the timer, polling state and
// read path together. Assumes start_i is a single-cycle pulse.
module pe_status_top
    import pe_status_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int PROG_CYCLES  = 40,
    parameter int ERASE_CYCLES = 300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_erase_i,
    input  logic [DATA_W-1:0] load_byte_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] array_byte_i,
    output logic [DATA_W-1:0] rd_byte_o,
    output logic              rd_oe_o,
    output logic              busy_drv_o,
    output logic              done_o
);
    op_kind_e op_kind;
    logic     accept;
    logic     busy;
    logic     poll_msb;
    logic     tog;

    assign op_kind = op_kind_e'(op_erase_i);

    pe_op_timer #(
        .PROG_CYCLES (PROG_CYCLES),
        .ERASE_CYCLES(ERASE_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .op_i    (op_kind),
        .accept_o(accept),
        .busy_o  (busy),
        .done_o  (done_o)
    );

    pe_poll_tracker u_poll (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .op_i      (op_kind),
        .load_msb_i(load_byte_i[DATA_W-1]),
        .rd_i      (rd_i),
        .busy_i    (busy),
        .poll_msb_o(poll_msb),
        .tog_o     (tog)
    );

    pe_read_mux #(
        .DATA_W(DATA_W)
    ) u_mux (
        .rst_n     (rst_n),
        .rd_i      (rd_i),
        .busy_i    (busy),
        .poll_msb_i(poll_msb),
        .tog_i     (tog),
        .array_i   (array_byte_i),
        .rd_byte_o (rd_byte_o),
        .rd_oe_o   (rd_oe_o)
    );

    assign busy_drv_o = busy;

    p_reset_abort_r10: assert property (@(posedge clk)
        !rst_n |=> (!busy_drv_o && !done_o));
    p_idle_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_drv_o |-> (rd_byte_o == array_byte_i));
    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_drv_o) |=> busy_drv_o);
    p_low_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_drv_o |-> (rd_byte_o[DATA_W-3:0] == array_byte_i[DATA_W-3:0]));
endmodule

// File: tb/pe_status_top_test.sv
module pe_status_top_test;
    localparam int DW = 8;
    localparam int PC = 4;
    localparam int EC = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          op_erase_i = 1'b0;
    logic [DW-1:0] load_byte_i = '0;
    logic          rd_i = 1'b0;
    logic [DW-1:0] array_byte_i = '0;
    logic [DW-1:0] rd_byte_o;
    logic          rd_oe_o;
    logic          busy_drv_o;
    logic          done_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic tog_m = 1'b0;

    pe_status_top #(.DATA_W(DW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_erase_i(op_erase_i),
        .load_byte_i(load_byte_i), .rd_i(rd_i), .array_byte_i(array_byte_i),
        .rd_byte_o(rd_byte_o), .rd_oe_o(rd_oe_o), .busy_drv_o(busy_drv_o),
        .done_o(done_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [DW-1:0] arr_pat(input int a, input int b);
        return DW'((a * 37 + b * 91 + 13) & 8'hFF);
    endfunction

    // One operation from an idle cycle: reads where mask bit set.
    task automatic run_op(input logic er, input logic [DW-1:0] b, input int mask);
        int dur;
        logic m7;
        logic [DW-1:0] a;
        dur = er ? EC : PC;
        m7 = er ? 1'b0 : ~b[7];
        start_i = 1'b1; op_erase_i = er; load_byte_i = b; rd_i = 1'b0;
        #4 chk("R2 idle before start", busy_drv_o, 0);
        tick();
        start_i = 1'b0;
        for (int k = 0; k < dur; k++) begin
            rd_i = mask[k];
            a = arr_pat(k, b);
            array_byte_i = a;
            #4;
            chk(er ? "R3 busy held" : "R2 busy held", busy_drv_o, 1);
            chk("R4 no early done", done_o, 0);
            if (rd_i) begin
                chk(er ? "R6 erase bit7" : "R5 program bit7", rd_byte_o[7], m7);
                chk("R7 toggle bit6", rd_byte_o[6], tog_m);
                chk("R8 low bits busy", rd_byte_o[5:0], a[5:0]);
                chk("R11 oe follows read", rd_oe_o, 1);
                tog_m = ~tog_m;
            end else begin
                chk("R11 oe low without read", rd_oe_o, 0);
            end
            tick();
        end
        rd_i = 1'b1;
        a = arr_pat(99, b);
        array_byte_i = a;
        #4;
        chk(er ? "R3 busy released" : "R2 busy released", busy_drv_o, 0);
        chk("R4 done pulse", done_o, 1);
        chk("R8 idle true data", rd_byte_o, a);
        tick();
        rd_i = 1'b0;
        #4 chk("R4 done single", done_o, 0);
    endtask

    initial begin
        // Reset state
        rd_i = 1'b1;
        #4 chk("R1 oe low in reset", rd_oe_o, 0);
        tick(); tick();
        rd_i = 1'b0;
        #4;
        chk("R1 busy low after reset", busy_drv_o, 0);
        chk("R1 done low after reset", done_o, 0);
        rst_n = 1'b1;
        tick();

        // Program sweep over every byte value, reading each busy cycle
        for (int v = 0; v < 256; v++) begin
            run_op(1'b0, DW'(v), 32'hFFFF_FFFF);
            tick();
        end
        // Erase sweep over every read pattern
        for (int m = 0; m < (1 << EC); m++) begin
            run_op(1'b1, DW'(m * 5), m);
            tick();
        end

        // R9: start while busy is ignored
        start_i = 1'b1; op_erase_i = 1'b0; load_byte_i = 8'h00;
        tick();
        start_i = 1'b1; op_erase_i = 1'b1; load_byte_i = 8'h80;
        rd_i = 1'b1;
        #4 chk("R9 bit7 keeps first capture", rd_byte_o[7], 1);
        tog_m = ~tog_m;
        tick();
        start_i = 1'b0;
        for (int k = 1; k < PC; k++) begin
            #4;
            chk("R9 busy not shortened", busy_drv_o, 1);
            chk("R9 bit7 unchanged", rd_byte_o[7], 1);
            tog_m = ~tog_m;
            tick();
        end
        rd_i = 1'b0;
        #4;
        chk("R9 duration not extended", busy_drv_o, 0);
        chk("R4 done after ignored start", done_o, 1);

        // R12: start in the done cycle
        start_i = 1'b1; op_erase_i = 1'b0; load_byte_i = 8'h7F;
        tick();
        start_i = 1'b0; rd_i = 1'b1; array_byte_i = 8'h3C;
        #4;
        chk("R12 restart in done cycle", busy_drv_o, 1);
        chk("R12 new bit7 captured", rd_byte_o[7], 1);
        chk("R7 toggle carries over", rd_byte_o[6], tog_m);
        tog_m = ~tog_m;
        tick();

        // R10: reset during the operation
        rst_n = 1'b0;
        #4 chk("R10 oe low in reset", rd_oe_o, 0);
        tick();
        rst_n = 1'b1; rd_i = 1'b0;
        tog_m = 1'b0;
        for (int k = 0; k < PC + 2; k++) begin
            #4;
            chk("R10 busy aborted", busy_drv_o, 0);
            chk("R10 no done after abort", done_o, 0);
            tick();
        end
        // R1: toggle restarts at 0 after reset
        run_op(1'b0, 8'hA5, 32'hFFFF_FFFF);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule